// File: doc/BRIEF.md
# In-Order Retirement Result Checker

This block sits behind a speculative core and re-executes, in program order, every instruction the core retires. Each retirement record brings the core's view of the instruction: its PC, its instruction word, the two source operand values it read, the result it produced and the next PC it chose. The checker keeps its own architectural PC and its own 8-entry register file. It fetches the instruction at its own PC through a combinational fetch port, reads its own operands and recomputes both the result and the next PC. It then compares every field of the record against its own values, each field separately.

The checker always commits its own values. A clean record simply retires. Any mismatch raises a per-field flag on the commit. The checker then spends one cycle in recovery mode, with its input closed. In that cycle it executes one more instruction using only its own PC, fetch and registers. It then pulses a restart to the core, carrying the PC the core must resume from, and returns to check mode. A saturating counter reports how many records needed correcting.

Top module: `retire_checker`

## Requirements
- R1: After reset, rec_ready is 1, cmt_valid and restart are 0, corr_count is 0 and fetch_pc equals RESET_PC (default 0).
- R2: Instruction word layout is op[31:28], rd[27:25], rs1[24:22], rs2[21:19] and a signed immediate imm[18:0]. The ops are: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left by rs2[4:0], 6 logical shift right by rs2[4:0], 7 signed set-less-than (result 1 or 0), and 8 add rs1 plus the sign-extended immediate. Each writes its result to rd and sets the next PC to PC+4.
- R3: Op 9 branches when rs1 equals rs2 and op 10 branches when they differ. A taken branch goes to PC+4+(imm<<2) and a not-taken one to PC+4. Branches and ops 11 to 15 produce result 0 and write no register.
- R4: Register 0 always reads as zero. A commit that targets it reports cmt_wen 0.
- R5: Five comparisons run on each accepted record, and each has its own bit in cmt_mismatch. Bit 0 compares rec_pc with the checker's PC. Bit 1 compares rec_instr with fetch_instr. Bit 2 compares rec_opa and rec_opb with the checker's rs1 and rs2 register values. Bit 3 compares rec_result with the recomputed result. Bit 4 compares rec_next_pc with the recomputed next PC. The committed data is always the checker's own result.
- R6: A record with no mismatch commits with cmt_mismatch 0 and raises no restart. The checker's PC moves to the recomputed next PC.
- R7: A mismatching record is followed by exactly one recovery commit (cmt_recovered 1). That commit executes the instruction at the corrected next PC from the checker's own state. In the same cycle, restart pulses with restart_pc equal to the PC after that instruction. The checker is in check mode on the following cycle.
- R8: rec_ready is 0 during the recovery cycle. A record offered then is ignored and produces no commit.
- R9: corr_count increments once per mismatching record and saturates at 2^CNT_W-1.
- R10: All commit and restart outputs appear in the cycle after the handshake or recovery step that caused them. cmt_valid is a one-cycle pulse per commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rec_valid | input | 1 | Retirement record present |
| rec_ready | output | 1 | Checker accepts a record (check mode) |
| rec_pc | input | 32 | Core's PC of the instruction |
| rec_instr | input | 32 | Core's instruction word |
| rec_opa | input | 32 | Core's rs1 operand value |
| rec_opb | input | 32 | Core's rs2 operand value |
| rec_result | input | 32 | Core's result |
| rec_next_pc | input | 32 | Core's next PC |
| fetch_pc | output | 32 | Checker's own PC, address of its fetch |
| fetch_instr | input | 32 | Instruction word at fetch_pc, same cycle |
| cmt_valid | output | 1 | Commit pulse |
| cmt_wen | output | 1 | Commit writes a register |
| cmt_rd | output | 3 | Destination register of the commit |
| cmt_data | output | 32 | Checker-computed result |
| cmt_pc | output | 32 | PC of the committed instruction |
| cmt_recovered | output | 1 | Commit came from recovery mode |
| cmt_mismatch | output | 5 | Per-comparison mismatch flags |
| restart | output | 1 | Restart pulse to the core |
| restart_pc | output | 32 | PC the core resumes from |
| corr_count | output | CNT_W | Saturating count of corrected records |

## Verification
The properties take for granted that fetch_instr is a pure function of fetch_pc within the cycle. They also take for granted that rec_valid is only meaningful while rec_ready is high, so data offered during recovery must leave no trace. The bench serves instructions from a small fixed program indexed by fetch_pc. It drives every record at the falling edge and only counts a handshake where the bench saw rec_ready high. During recovery cycles it deliberately keeps rec_valid high with garbage fields, which exercises the ignore rule without breaking the fetch assumption.

// File: rtl/chk_pkg.sv
package chk_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned NREG    = 8;
  localparam int unsigned RIDX    = $clog2(NREG);
  localparam int unsigned IMM_W   = 19;
  localparam int unsigned NFLAG   = 5;

  // mismatch flag positions
  localparam int unsigned FL_PC   = 0;
  localparam int unsigned FL_INS  = 1;
  localparam int unsigned FL_OPR  = 2;
  localparam int unsigned FL_RES  = 3;
  localparam int unsigned FL_NPC  = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_ADDI = 4'd8,
    OP_BEQ  = 4'd9,
    OP_BNE  = 4'd10
  } op_e;

  typedef enum logic {
    ST_CHECK = 1'b0,
    ST_RECOV = 1'b1
  } mode_e;
endpackage

// File: rtl/chk_regfile.sv
module chk_regfile
  import chk_pkg::*;
#(
  parameter int unsigned W = XLEN,
  parameter int unsigned N = NREG,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [N-1:0][W-1:0] bank;

  assign bank[0] = '0;

  for (genvar g = 1; g < N; g++) begin : g_ent
    logic [W-1:0] q;
    logic         en;
    assign en = we && (wa == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wd;
    end
    assign bank[g] = q;
  end

  assign rd_a = bank[ra_a];
  assign rd_b = bank[ra_b];
endmodule

// File: rtl/chk_exec.sv
module chk_exec
  import chk_pkg::*;
#(
  parameter int unsigned W = XLEN,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [31:0]   instr,
  input  logic [W-1:0]  pc,
  input  logic [W-1:0]  va,
  input  logic [W-1:0]  vb,
  output logic [RIDX-1:0] rs1,
  output logic [RIDX-1:0] rs2,
  output logic [RIDX-1:0] rd,
  output logic [W-1:0]  result,
  output logic [W-1:0]  next_pc,
  output logic          wen
);
  logic [3:0]       op;
  logic [IMM_W-1:0] imm;
  logic [W-1:0]     simm;
  logic [W-1:0]     seq_pc;
  logic             writes;

  assign op     = instr[31:28];
  assign rd     = instr[27:25];
  assign rs1    = instr[24:22];
  assign rs2    = instr[21:19];
  assign imm    = instr[IMM_W-1:0];
  assign simm   = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
  assign seq_pc = pc + W'(4);

  always_comb begin
    result  = '0;
    next_pc = seq_pc;
    writes  = 1'b0;
    case (op)
      OP_ADD:  begin result = va + vb;              writes = 1'b1; end
      OP_SUB:  begin result = va - vb;              writes = 1'b1; end
      OP_AND:  begin result = va & vb;              writes = 1'b1; end
      OP_OR:   begin result = va | vb;              writes = 1'b1; end
      OP_XOR:  begin result = va ^ vb;              writes = 1'b1; end
      OP_SLL:  begin result = va << vb[SHW-1:0];    writes = 1'b1; end
      OP_SRL:  begin result = va >> vb[SHW-1:0];    writes = 1'b1; end
      OP_SLT:  begin result = W'($signed(va) < $signed(vb)); writes = 1'b1; end
      OP_ADDI: begin result = va + simm;            writes = 1'b1; end
      OP_BEQ:  if (va == vb) next_pc = seq_pc + (simm << 2);
      OP_BNE:  if (va != vb) next_pc = seq_pc + (simm << 2);
      default: ;
    endcase
  end

  assign wen = writes && (rd != '0);
endmodule

// File: rtl/chk_compare.sv
module chk_compare
  import chk_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [W-1:0]     core_pc,
  input  logic [31:0]      core_instr,
  input  logic [W-1:0]     core_opa,
  input  logic [W-1:0]     core_opb,
  input  logic [W-1:0]     core_result,
  input  logic [W-1:0]     core_npc,
  input  logic [W-1:0]     own_pc,
  input  logic [31:0]      own_instr,
  input  logic [W-1:0]     own_opa,
  input  logic [W-1:0]     own_opb,
  input  logic [W-1:0]     own_result,
  input  logic [W-1:0]     own_npc,
  output logic [NFLAG-1:0] flags
);
  always_comb begin
    flags         = '0;
    flags[FL_PC]  = core_pc     != own_pc;
    flags[FL_INS] = core_instr  != own_instr;
    flags[FL_OPR] = (core_opa != own_opa) || (core_opb != own_opb);
    flags[FL_RES] = core_result != own_result;
    flags[FL_NPC] = core_npc    != own_npc;
  end
endmodule

// File: rtl/retire_checker.sv
module retire_checker
  import chk_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter int unsigned     CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [XLEN-1:0]   rec_pc,
  input  logic [31:0]       rec_instr,
  input  logic [XLEN-1:0]   rec_opa,
  input  logic [XLEN-1:0]   rec_opb,
  input  logic [XLEN-1:0]   rec_result,
  input  logic [XLEN-1:0]   rec_next_pc,
  output logic [XLEN-1:0]   fetch_pc,
  input  logic [31:0]       fetch_instr,
  output logic              cmt_valid,
  output logic              cmt_wen,
  output logic [RIDX-1:0]   cmt_rd,
  output logic [XLEN-1:0]   cmt_data,
  output logic [XLEN-1:0]   cmt_pc,
  output logic              cmt_recovered,
  output logic [NFLAG-1:0]  cmt_mismatch,
  output logic              restart,
  output logic [XLEN-1:0]   restart_pc,
  output logic [CNT_W-1:0]  corr_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mode_e             mode_q, mode_d;
  logic [XLEN-1:0]   pc_q, pc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic [RIDX-1:0]   rs1, rs2, rd;
  logic [XLEN-1:0]   va, vb, own_res, own_npc;
  logic              own_wen;
  logic [NFLAG-1:0]  cmp_flags, flags;
  logic              accept, step, mis;

  chk_exec #(.W(XLEN)) u_exec (
    .instr(fetch_instr), .pc(pc_q), .va(va), .vb(vb),
    .rs1(rs1), .rs2(rs2), .rd(rd),
    .result(own_res), .next_pc(own_npc), .wen(own_wen)
  );

  chk_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst_n(rst_sync_n),
    .we(step && own_wen), .wa(rd), .wd(own_res),
    .ra_a(rs1), .ra_b(rs2), .rd_a(va), .rd_b(vb)
  );

  chk_compare #(.W(XLEN)) u_cmp (
    .core_pc(rec_pc), .core_instr(rec_instr), .core_opa(rec_opa),
    .core_opb(rec_opb), .core_result(rec_result), .core_npc(rec_next_pc),
    .own_pc(pc_q), .own_instr(fetch_instr), .own_opa(va), .own_opb(vb),
    .own_result(own_res), .own_npc(own_npc), .flags(cmp_flags)
  );

  assign rec_ready = (mode_q == ST_CHECK);
  assign fetch_pc  = pc_q;
  assign accept    = rec_ready && rec_valid;
  assign step      = accept || (mode_q == ST_RECOV);
  assign flags     = accept ? cmp_flags : '0;
  assign mis       = |flags;

  // next state
  always_comb begin
    mode_d = mode_q;
    pc_d   = pc_q;
    cnt_d  = cnt_q;
    if (step) pc_d = own_npc;
    case (mode_q)
      ST_CHECK: if (accept && mis) mode_d = ST_RECOV;
      ST_RECOV: mode_d = ST_CHECK;
      default:  mode_d = ST_CHECK;
    endcase
    if (accept && mis && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= ST_CHECK;
      pc_q   <= RESET_PC;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      if (step)   pc_q  <= pc_d;
      if (accept) cnt_q <= cnt_d;
    end
  end

  // commit and restart registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmt_valid     <= 1'b0;
      cmt_wen       <= 1'b0;
      cmt_rd        <= '0;
      cmt_data      <= '0;
      cmt_pc        <= '0;
      cmt_recovered <= 1'b0;
      cmt_mismatch  <= '0;
      restart       <= 1'b0;
      restart_pc    <= '0;
    end else begin
      cmt_valid <= step;
      restart   <= (mode_q == ST_RECOV);
      if (step) begin
        cmt_wen       <= own_wen;
        cmt_rd        <= rd;
        cmt_data      <= own_res;
        cmt_pc        <= pc_q;
        cmt_recovered <= (mode_q == ST_RECOV);
        cmt_mismatch  <= flags;
      end
      if (mode_q == ST_RECOV) restart_pc <= own_npc;
    end
  end

  assign corr_count = cnt_q;

  // ---------------- assertions ----------------
  assert_recover_follows_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmt_valid && (cmt_mismatch != '0)) |=> (cmt_valid && cmt_recovered && restart));

  assert_closed_in_recovery_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmt_valid && (cmt_mismatch != '0)) |-> !rec_ready);

  assert_back_to_check_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    restart |-> (rec_ready && cmt_recovered));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmt_valid && (cmt_mismatch != '0) && ($past(corr_count) != CNT_MAX))
      |-> (corr_count == $past(corr_count) + 1'b1));

  assert_no_zero_write_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmt_wen |-> (cmt_rd != '0));

  assert_pc_holds_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rec_ready && !rec_valid) |=> $stable(fetch_pc));
endmodule

// File: tb/retire_checker_test.sv
module retire_checker_test;
  localparam int unsigned CW = 3;
  localparam logic [CW-1:0] CMAX = '1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rec_valid;
  logic        rec_ready;
  logic [31:0] rec_pc, rec_instr, rec_opa, rec_opb, rec_result, rec_next_pc;
  logic [31:0] fetch_pc, fetch_instr;
  logic        cmt_valid, cmt_wen, cmt_recovered, restart;
  logic [2:0]  cmt_rd;
  logic [31:0] cmt_data, cmt_pc, restart_pc;
  logic [4:0]  cmt_mismatch;
  logic [CW-1:0] corr_count;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] imem [16];
  logic [31:0] mregs [8];
  logic [31:0] mpc;
  logic [CW-1:0] mcnt;

  always #10 clk = ~clk;

  assign fetch_instr = imem[fetch_pc[5:2]];

  retire_checker #(.RESET_PC(32'h0), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_pc(rec_pc), .rec_instr(rec_instr), .rec_opa(rec_opa), .rec_opb(rec_opb),
    .rec_result(rec_result), .rec_next_pc(rec_next_pc),
    .fetch_pc(fetch_pc), .fetch_instr(fetch_instr),
    .cmt_valid(cmt_valid), .cmt_wen(cmt_wen), .cmt_rd(cmt_rd), .cmt_data(cmt_data),
    .cmt_pc(cmt_pc), .cmt_recovered(cmt_recovered), .cmt_mismatch(cmt_mismatch),
    .restart(restart), .restart_pc(restart_pc), .corr_count(corr_count)
  );

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [2:0] d,
                                      input logic [2:0] a, input logic [2:0] b,
                                      input int imm);
    logic [31:0] v;
    v = {op, d, a, b, 19'(imm)};
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // reference model of one instruction, written from R2/R3/R4
  task automatic model(input logic [31:0] ins, input logic [31:0] pc,
                       output logic [31:0] res, output logic [31:0] npc,
                       output logic wr, output logic [31:0] a, output logic [31:0] b);
    logic [31:0] simm;
    a    = mregs[ins[24:22]];
    b    = mregs[ins[21:19]];
    simm = {{13{ins[18]}}, ins[18:0]};
    res  = 32'h0;
    npc  = pc + 32'd4;
    wr   = 1'b0;
    case (ins[31:28])
      4'd0: begin res = a + b; wr = 1'b1; end
      4'd1: begin res = a - b; wr = 1'b1; end
      4'd2: begin res = a & b; wr = 1'b1; end
      4'd3: begin res = a | b; wr = 1'b1; end
      4'd4: begin res = a ^ b; wr = 1'b1; end
      4'd5: begin res = a << b[4:0]; wr = 1'b1; end
      4'd6: begin res = a >> b[4:0]; wr = 1'b1; end
      4'd7: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; wr = 1'b1; end
      4'd8: begin res = a + simm; wr = 1'b1; end
      4'd9:  if (a == b) npc = pc + 32'd4 + (simm << 2);
      4'd10: if (a != b) npc = pc + 32'd4 + (simm << 2);
      default: ;
    endcase
    if (ins[27:25] == 3'd0) wr = 1'b0;
  endtask

  // send one record; corrupt selects fields to damage (flag bit layout of R5)
  task automatic send(input logic [4:0] corrupt, input string req);
    logic [31:0] ins, res, npc, a, b;
    logic wr;
    chk("R8", "ready before record", {31'h0, rec_ready}, 32'd1);
    ins = imem[mpc[5:2]];
    model(ins, mpc, res, npc, wr, a, b);
    rec_pc      = mpc ^ (corrupt[0] ? 32'd4 : 32'd0);
    rec_instr   = ins ^ (corrupt[1] ? 32'h0002_0000 : 32'd0);
    rec_opa     = a ^ (corrupt[2] ? 32'd1 : 32'd0);
    rec_opb     = b;
    rec_result  = res ^ (corrupt[3] ? 32'd1 : 32'd0);
    rec_next_pc = npc ^ (corrupt[4] ? 32'd4 : 32'd0);
    rec_valid   = 1'b1;
    @(negedge clk);
    rec_valid = 1'b0;
    chk(req, "R10 commit pulse", {31'h0, cmt_valid}, 32'd1);
    chk(req, "commit data", cmt_data, res);
    chk(req, "commit pc", cmt_pc, mpc);
    chk(req, "R4 write enable", {31'h0, cmt_wen}, {31'h0, wr});
    if (wr) chk(req, "commit rd", {29'h0, cmt_rd}, {29'h0, ins[27:25]});
    chk("R5", "mismatch flags", {27'h0, cmt_mismatch}, {27'h0, corrupt});
    chk(req, "not recovered", {31'h0, cmt_recovered}, 32'd0);
    chk(req, "no restart yet", {31'h0, restart}, 32'd0);
    if (wr) mregs[ins[27:25]] = res;
    mpc = npc;
    if (corrupt != 5'd0) begin
      if (mcnt != CMAX) mcnt = mcnt + 1'b1;
      chk("R9", "correction count", {29'h0, corr_count}, {29'h0, mcnt});
      chk("R8", "ready low in recovery", {31'h0, rec_ready}, 32'd0);
      // junk offered during recovery must be ignored
      rec_pc = 32'hDEAD_BEEF; rec_result = 32'h1234_5678; rec_valid = 1'b1;
      ins = imem[mpc[5:2]];
      model(ins, mpc, res, npc, wr, a, b);
      @(negedge clk);
      rec_valid = 1'b0;
      chk("R7", "recovery commit", {31'h0, cmt_valid}, 32'd1);
      chk("R7", "recovered flag", {31'h0, cmt_recovered}, 32'd1);
      chk("R7", "recovery data", cmt_data, res);
      chk("R7", "recovery pc", cmt_pc, mpc);
      chk("R7", "recovery flags clear", {27'h0, cmt_mismatch}, 32'd0);
      chk("R7", "restart pulse", {31'h0, restart}, 32'd1);
      chk("R7", "restart pc", restart_pc, npc);
      if (wr) mregs[ins[27:25]] = res;
      mpc = npc;
      chk("R7", "back in check mode", {31'h0, rec_ready}, 32'd1);
      @(negedge clk);
      chk("R8", "junk left no commit", {31'h0, cmt_valid}, 32'd0);
      chk("R10", "restart one cycle", {31'h0, restart}, 32'd0);
      chk("R8", "pc unchanged by junk", fetch_pc, mpc);
    end else begin
      chk("R6", "count unchanged", {29'h0, corr_count}, {29'h0, mcnt});
      chk("R6", "pc advanced", fetch_pc, mpc);
    end
  endtask

  task automatic t_reset();
    chk("R1", "ready", {31'h0, rec_ready}, 32'd1);
    chk("R1", "no commit", {31'h0, cmt_valid}, 32'd0);
    chk("R1", "no restart", {31'h0, restart}, 32'd0);
    chk("R1", "count zero", {29'h0, corr_count}, 32'd0);
    chk("R1", "fetch pc", fetch_pc, 32'd0);
  endtask

  task automatic t_alu();
    for (int i = 0; i < 10; i++) send(5'd0, "R2");
  endtask

  task automatic t_zero_reg();
    send(5'd0, "R4");   // addi r0 <- 7, no write
    send(5'd0, "R4");   // add r6 = r0 + r0 -> 0
  endtask

  task automatic t_branch();
    for (int i = 0; i < 3; i++) send(5'd0, "R3");
    chk("R3", "loop back to zero", mpc, 32'd0);
  endtask

  task automatic t_mismatch();
    for (int k = 0; k < 5; k++) send(5'(1 << k), "R5");
    send(5'b11010, "R7");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 4; i++) send(5'b01000, "R9");
    chk("R9", "saturated", {29'h0, corr_count}, {29'h0, CMAX});
    send(5'd0, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired act=%0d exp=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    imem[0]  = enc(4'd8, 3'd1, 3'd0, 3'd0, 5);
    imem[1]  = enc(4'd8, 3'd2, 3'd0, 3'd0, -3);
    imem[2]  = enc(4'd0, 3'd3, 3'd1, 3'd2, 0);
    imem[3]  = enc(4'd1, 3'd4, 3'd1, 3'd2, 0);
    imem[4]  = enc(4'd2, 3'd5, 3'd1, 3'd2, 0);
    imem[5]  = enc(4'd3, 3'd6, 3'd1, 3'd2, 0);
    imem[6]  = enc(4'd4, 3'd7, 3'd1, 3'd2, 0);
    imem[7]  = enc(4'd5, 3'd3, 3'd1, 3'd1, 0);
    imem[8]  = enc(4'd6, 3'd4, 3'd2, 3'd1, 0);
    imem[9]  = enc(4'd7, 3'd5, 3'd2, 3'd1, 0);
    imem[10] = enc(4'd8, 3'd0, 3'd0, 3'd0, 7);
    imem[11] = enc(4'd0, 3'd6, 3'd0, 3'd0, 0);
    imem[12] = enc(4'd9, 3'd0, 3'd1, 3'd1, 1);
    imem[13] = enc(4'd8, 3'd7, 3'd0, 3'd0, 99);
    imem[14] = enc(4'd10, 3'd0, 3'd1, 3'd1, 5);
    imem[15] = enc(4'd10, 3'd0, 3'd1, 3'd2, -16);
    for (int r = 0; r < 8; r++) mregs[r] = 32'h0;
    mpc = 32'h0;
    mcnt = '0;
    rec_valid = 1'b0;
    rec_pc = '0; rec_instr = '0; rec_opa = '0; rec_opb = '0;
    rec_result = '0; rec_next_pc = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_alu();
    t_zero_reg();
    t_branch();
    t_mismatch();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule